// File: doc/BRIEF.md
# Pointer-Addressed Serial Channel Register Front End

This block is the register front end of one serial channel. Software reaches it through two byte-wide ports inside a 16-byte window: a control port at offset 0 and a data port at offset 8. Most registers are reached in two steps. A control-port write with the pointer at zero carries a register number and, when needed, a command. The next control-port access, read or write, reaches the selected register. The pointer then drops back to zero.

The block keeps the interrupt-enable and master-control settings. It latches modem-line status, holds a one-byte receive buffer and a one-byte transmit buffer, and tracks three pending interrupt sources: receive, transmit and external/status. These sources are merged into one interrupt request, gated by a master enable and by an enable for each source. The serial shift engines sit outside the block. They hand in received characters with error flags, take transmit bytes, and drive the modem-status lines.

Top module: `serial_reg_front`

## Requirements
- R1: After reset the pointer is 0 and the request output is low. Status register 0 reads 0x04 when the modem lines are low. Status register 1 reads 0x01, and status register 3 reads 0x00.
- R2: A control write at pointer 0 selects register `wdata[2:0]` for the next control access. After a control access at any nonzero pointer, the pointer returns to 0. Readable registers: 0 (line status), 1 (error status), 3 (pending). All others read 0x00.
- R3: A pointer-0 control write with `wdata[5:3]` = 001 (byte 0x08|n) selects register 8+n.
- R4: Register 9 bit 3 is the master interrupt enable. Writing 0xC0 to register 9 returns every flag, enable and the pointer to their reset values.
- R5: A data-port write loads `tx_data`, raises `tx_loaded` and clears status-0 bit 2 (transmit empty). A `tx_taken` pulse sets bit 2 again. Status-1 bit 0 mirrors bit 2.
- R6: A data-port read returns the last received character and clears status-0 bit 0 (character available).
- R7: Transmit pending (a bit in status 3) sets on `tx_taken` when register 1 bit 1 is set. It clears on command code 101 (0x28) or on a data-port write.
- R8: Register 1 bits 4:3 pick the receive mode. 00 gives no receive request. 01 requests on the first character after re-arm command 100 (0x20), or on an error. 10 requests on every character or error. 11 requests on errors only. A character request clears when the data port is read.
- R9: Status-1 bit 4 is parity error, bit 5 is overrun and bit 6 is framing error. Overrun means a character arrived while one was still unread. The flags stay set until command code 110 (0x30).
- R10: With register 1 bit 0 set, a change on DCD, CTS or break sets external pending. While pending, status 0 holds DCD at bit 3, CTS at bit 5 and break at bit 7, frozen. Command code 010 (0x10) clears pending. With the enable clear, status 0 follows the lines one cycle late.
- R11: Status 3 places external, transmit and receive pending at bits 3, 4, 5 when `CHAN_A` is 1, or at bits 0, 1, 2 otherwise.
- R12: `irq` is high exactly when the master enable is set and an enabled pending source is set.
- R13: Command code 111 (0x38) clears the highest-priority pending source: receive first, then transmit, then external. It leaves the buffers untouched.
- R14: Accesses to offsets other than 0 and 8 change nothing and read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Window select |
| wr_en | input | 1 | Write strobe (wins over read) |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset in window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error with character |
| rx_ferr | input | 1 | Framing error with character |
| tx_data | output | 8 | Transmit buffer |
| tx_loaded | output | 1 | Transmit buffer holds a byte |
| tx_taken | input | 1 | Engine took the transmit byte |
| dcd | input | 1 | Carrier detect line |
| cts | input | 1 | Clear-to-send line |
| brk | input | 1 | Break detected |

## Verification
A pointer that fails to return to zero shows on the very next control read, which returns the wrong register instead of line status. Every pointer value is swept for this. A pending flag that is set or cleared wrongly shows on `irq` in the cycle after the event, and in the pending register on the next read. This is checked for each receive mode with and without errors, and for each reset command. A wrong status snapshot shows as status-0 bits that change while they should be frozen, or stay frozen after the reset command.

// File: rtl/serial_reg_front.sv
module serial_reg_front #(
  parameter bit CHAN_A = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       rx_valid,
  input  logic [7:0] rx_char,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  output logic [7:0] tx_data,
  output logic       tx_loaded,
  input  logic       tx_taken,
  input  logic       dcd,
  input  logic       cts,
  input  logic       brk
);
  logic [3:0] ptr;
  logic [4:0] en1;
  logic       mie;
  logic       tx_empty, rx_avail, rx_chr_ip, first_arm;
  logic       perr, ferr, ovr, tx_ip, ext_ip;
  logic [2:0] snap;
  logic [7:0] rxbuf;

  wire ctl_acc = cs && (wr_en || rd_en) && addr == 4'h0;
  wire dat_acc = cs && (wr_en || rd_en) && addr == 4'h8;
  wire ctl_wr  = ctl_acc && wr_en;
  wire ctl_rd  = ctl_acc && !wr_en;
  wire dat_wr  = dat_acc && wr_en;
  wire dat_rd  = dat_acc && !wr_en;
  wire cmd_wr  = ctl_wr && ptr == 4'd0;
  wire [2:0] cmd = wdata[5:3];
  wire hard_rst = ctl_wr && ptr == 4'd9 && wdata[7:6] == 2'b11;
  wire [2:0] live = {brk, cts, dcd};
  wire [1:0] rx_mode = en1[4:3];
  wire rx_ip = rx_chr_ip || ((perr || ferr || ovr) && rx_mode != 2'b00);

  assign irq = mie && ((ext_ip && en1[0]) || (tx_ip && en1[1]) || rx_ip);
  assign tx_loaded = !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; en1 <= '0; mie <= 1'b0; tx_empty <= 1'b1; rx_avail <= 1'b0;
      rx_chr_ip <= 1'b0; first_arm <= 1'b1; perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0;
      tx_ip <= 1'b0; ext_ip <= 1'b0; snap <= '0; rxbuf <= '0; tx_data <= '0;
    end else if (hard_rst) begin
      ptr <= '0; en1 <= '0; mie <= 1'b0; tx_empty <= 1'b1; rx_avail <= 1'b0;
      rx_chr_ip <= 1'b0; first_arm <= 1'b1; perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0;
      tx_ip <= 1'b0; ext_ip <= 1'b0; snap <= live;
    end else begin
      if (ctl_acc) begin
        if (ptr != 4'd0) ptr <= 4'd0;
        else if (wr_en) ptr <= {cmd == 3'b001, wdata[2:0]};
      end
      if (ctl_wr && ptr == 4'd1) en1 <= wdata[4:0];
      if (ctl_wr && ptr == 4'd9) mie <= wdata[3];

      if (!ext_ip) snap <= live;
      if (!ext_ip && en1[0] && live != snap) ext_ip <= 1'b1;

      if (dat_rd) begin
        rx_avail <= 1'b0;
        rx_chr_ip <= 1'b0;
      end
      if (rx_valid) begin
        rxbuf <= rx_char;
        rx_avail <= 1'b1;
        if (rx_avail && !dat_rd) ovr <= 1'b1;
        if (rx_perr) perr <= 1'b1;
        if (rx_ferr) ferr <= 1'b1;
        if (rx_mode == 2'b10 || (rx_mode == 2'b01 && first_arm)) rx_chr_ip <= 1'b1;
        if (rx_mode == 2'b01) first_arm <= 1'b0;
      end

      if (tx_taken && !tx_empty) begin
        tx_empty <= 1'b1;
        if (en1[1]) tx_ip <= 1'b1;
      end
      if (dat_wr) begin
        tx_data <= wdata;
        tx_empty <= 1'b0;
        tx_ip <= 1'b0;
      end

      if (cmd_wr) begin
        case (cmd)
          3'b010: ext_ip <= 1'b0;
          3'b100: first_arm <= 1'b1;
          3'b101: tx_ip <= 1'b0;
          3'b110: begin perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0; end
          3'b111: begin
            if (rx_ip) begin
              rx_chr_ip <= 1'b0; perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0;
            end else if (tx_ip) tx_ip <= 1'b0;
            else ext_ip <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  logic [7:0] rr_sel;
  always_comb begin
    case (ptr)
      4'd0: rr_sel = {snap[2], 1'b0, snap[1], 1'b0, snap[0], tx_empty, 1'b0, rx_avail};
      4'd1: rr_sel = {1'b0, ferr, ovr, perr, 3'b000, tx_empty};
      4'd3: rr_sel = CHAN_A ? {2'b00, rx_ip, tx_ip, ext_ip, 3'b000}
                            : {5'b00000, rx_ip, tx_ip, ext_ip};
      default: rr_sel = 8'h00;
    endcase
  end
  assign rdata = dat_rd ? rxbuf : (ctl_rd ? rr_sel : 8'h00);

  p_ptr_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc && ptr != 4'd0) |=> ptr == 4'd0);
  p_full_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (ptr == 4'd0 && !irq && !tx_loaded));
  p_tx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> (tx_loaded && tx_data == $past(wdata)));
  p_rx_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !rx_valid) |=> !rx_avail);
  p_txip_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == 3'b101) |=> !tx_ip);
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_avail && !dat_rd && !hard_rst) |=> ovr);
endmodule

// File: tb/serial_reg_front_test.sv
module serial_reg_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rx_char = '0;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, tx_taken = 0;
  logic dcd = 0, cts = 0, brk = 0;
  logic [7:0] rdata, tx_data;
  logic irq, tx_loaded;
  int checks = 0, errors = 0;
  logic [7:0] q;

  always #4 clk = ~clk;

  serial_reg_front uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    cs = 1; wr_en = w; rd_en = !w; addr = a; wdata = d;
    #1 r = rdata;
    @(posedge clk); #1;
    cs = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic cwr(input logic [7:0] d); logic [7:0] x; acc(1, 4'h0, d, x); endtask
  task automatic crd(output logic [7:0] r); acc(0, 4'h0, 8'h00, r); endtask
  task automatic dwr(input logic [7:0] d); logic [7:0] x; acc(1, 4'h8, d, x); endtask
  task automatic drd(output logic [7:0] r); acc(0, 4'h8, 8'h00, r); endtask
  task automatic sel(input int n); cwr(n >= 8 ? (8'h08 | 8'(n & 7)) : 8'(n)); endtask
  task automatic rwr(input int n, input logic [7:0] d); sel(n); cwr(d); endtask
  task automatic rrd(input int n, output logic [7:0] r); sel(n); crd(r); endtask

  task automatic rx(input logic [7:0] c, input logic pe, input logic fe);
    @(negedge clk); rx_valid = 1; rx_char = c; rx_perr = pe; rx_ferr = fe;
    @(posedge clk); #1 rx_valid = 0; rx_perr = 0; rx_ferr = 0;
  endtask

  task automatic take();
    @(negedge clk); tx_taken = 1;
    @(posedge clk); #1 tx_taken = 0;
  endtask

  task automatic settle(); @(negedge clk); @(negedge clk); endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    crd(q); chk("R1 rr0", q, 8'h04);
    rrd(1, q); chk("R1 rr1", q, 8'h01);
    rrd(3, q); chk("R1 rr3", q, 8'h00);

    // R5 / R7 transmit path
    rwr(1, 8'h02);
    dwr(8'h5A);
    chk("R5 tx_data", tx_data, 8'h5A);
    chk("R5 tx_loaded", {7'b0, tx_loaded}, 8'h01);
    crd(q); chk("R5 rr0 empty clear", q, 8'h00);
    take();
    crd(q); chk("R5 rr0 empty set", q, 8'h04);
    rrd(3, q); chk("R7 R11 tx pending", q, 8'h10);

    // R2 R3 pointer sweep over all registers
    for (int n = 0; n < 16; n++) begin
      logic [7:0] e;
      e = (n == 0) ? 8'h04 : (n == 1) ? 8'h01 : (n == 3) ? 8'h10 : 8'h00;
      rrd(n, q); chk(n >= 8 ? "R3 point-high read" : "R2 pointer read", q, e);
      crd(q); chk("R2 pointer back to 0", q, 8'h04);
    end

    // R12 master enable gating
    settle(); chk("R12 irq masked", {7'b0, irq}, 8'h00);
    rwr(9, 8'h08);
    settle(); chk("R12 irq on", {7'b0, irq}, 8'h01);
    cwr(8'h28);
    settle(); chk("R7 irq after tx reset", {7'b0, irq}, 8'h00);
    rrd(3, q); chk("R7 pending clear", q, 8'h00);
    dwr(8'h11); take(); cwr(8'h28); dwr(8'h22);
    rrd(3, q); chk("R7 data write clears tx pending", q, 8'h00);
    take();
    cwr(8'h28);

    // R8 R9 R6 receive modes sweep
    for (int m = 0; m < 4; m++) begin
      logic [7:0] c;
      c = 8'h30 + 8'(m);
      rwr(1, 8'(m << 3));
      cwr(8'h20);
      rx(c, 0, 0);
      settle(); chk("R8 first char irq", {7'b0, irq}, (m == 1 || m == 2) ? 8'h01 : 8'h00);
      crd(q); chk("R6 rr0 avail", q, 8'h05);
      drd(q); chk("R6 data read", q, c);
      crd(q); chk("R6 avail cleared", q, 8'h04);
      settle(); chk("R8 irq after read", {7'b0, irq}, 8'h00);
      rx(c ^ 8'hFF, 0, 0);
      settle(); chk("R8 second char irq", {7'b0, irq}, (m == 2) ? 8'h01 : 8'h00);
      drd(q); chk("R6 second read", q, c ^ 8'hFF);
      rx(c + 8'h40, 0, 1);
      settle(); chk("R8 error irq", {7'b0, irq}, (m != 0) ? 8'h01 : 8'h00);
      drd(q);
      settle(); chk("R8 error irq held", {7'b0, irq}, (m != 0) ? 8'h01 : 8'h00);
      rrd(1, q); chk("R9 framing flag", q, 8'h41);
      cwr(8'h30);
      settle(); chk("R9 irq after error reset", {7'b0, irq}, 8'h00);
      rrd(1, q); chk("R9 flags cleared", q, 8'h01);
    end

    // R9 overrun and parity
    rwr(1, 8'h00);
    rx(8'hA1, 1, 0); rx(8'hA2, 0, 0);
    rrd(1, q); chk("R9 overrun+parity", q, 8'h31);
    drd(q); chk("R9 newest char kept", q, 8'hA2);
    cwr(8'h30);
    rrd(1, q); chk("R9 cleared", q, 8'h01);

    // R10 external status
    rwr(1, 8'h01);
    @(negedge clk) dcd = 1;
    settle();
    chk("R10 ext irq", {7'b0, irq}, 8'h01);
    crd(q); chk("R10 rr0 snapshot", q, 8'h0C);
    rrd(3, q); chk("R11 ext bit", q, 8'h08);
    @(negedge clk) cts = 1;
    settle();
    crd(q); chk("R10 rr0 frozen", q, 8'h0C);
    cwr(8'h10);
    settle();
    crd(q); chk("R10 rr0 updated", q, 8'h2C);
    cwr(8'h10);
    settle();
    chk("R10 irq cleared", {7'b0, irq}, 8'h00);
    rrd(3, q); chk("R10 pending cleared", q, 8'h00);
    rwr(1, 8'h00);
    @(negedge clk) brk = 1;
    settle();
    crd(q); chk("R10 disabled tracks", q, 8'hAC);
    rrd(3, q); chk("R10 disabled no pending", q, 8'h00);

    // R13 reset highest under service
    rwr(1, 8'h13);
    dwr(8'h77); take();
    @(negedge clk) dcd = 0;
    settle();
    rx(8'h99, 0, 0);
    rrd(3, q); chk("R13 all pending", q, 8'h38);
    cwr(8'h38); rrd(3, q); chk("R13 rx cleared first", q, 8'h18);
    cwr(8'h38); rrd(3, q); chk("R13 tx cleared next", q, 8'h08);
    cwr(8'h38); rrd(3, q); chk("R13 ext cleared last", q, 8'h00);
    crd(q); chk("R13 rx buffer kept", q, 8'hA5);

    // R14 other offsets ignored
    acc(1, 4'h4, 8'h09, q);
    acc(0, 4'hC, 8'h00, q); chk("R14 read other offset", q, 8'h00);
    crd(q); chk("R14 pointer untouched", q, 8'hA5);
    drd(q); chk("R14 rx buffer", q, 8'h99);

    // R4 full reset
    dwr(8'h44);
    rrd(9, q);
    rwr(9, 8'hC0);
    settle();
    chk("R4 irq low", {7'b0, irq}, 8'h00);
    chk("R4 tx_loaded low", {7'b0, tx_loaded}, 8'h00);
    crd(q); chk("R4 rr0", q, 8'hA4);
    rrd(1, q); chk("R4 rr1", q, 8'h01);
    rwr(1, 8'h02); dwr(8'h01); take();
    rrd(3, q); chk("R4 tx pending", q, 8'h10);
    settle(); chk("R4 master enable cleared", {7'b0, irq}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule